// File: doc/BRIEF.md
# Timer Clock-Enable Hub with Group Halt

This block sits in front of a set of timer/counters and gives each of them a single-cycle count enable. A shared free-running 10-bit divider chain produces enables at the system clock rate and at 1/8, 1/64, 1/256 and 1/1024 of it. Each timer has its own 3-bit source selector. The selector picks one of these enables, or stop, or an edge of that timer's own external pin. The pin is passed through a two-stage synchronizer, and a third register is used to compare edges. The resulting edge pulse goes straight to the timer and never passes through the divider.

An 8-bit control register holds two bits. Bit 0 restarts the divider. Bit 7 selects group-halt mode. A control state machine tracks the pair and has four named states:
- `CTL_FREE`: bit 7 = 0, bit 0 = 0. The divider runs.
- `CTL_CLEAR`: bit 7 = 0, bit 0 = 1. This is a one-cycle divider restart.
- `CTL_ARMED`: bit 7 = 1, bit 0 = 0. The divider runs.
- `CTL_HOLD`: bit 7 = 1, bit 0 = 1. The divider is held at zero.

Transitions on a write:
- A write with bit 7 = 1 goes to `CTL_HOLD` if bit 0 = 1, otherwise to `CTL_ARMED`.
- A write with bit 7 = 0 from `CTL_ARMED` or `CTL_HOLD` goes to `CTL_FREE`, whatever the value of bit 0.
- A write with bit 7 = 0 from `CTL_FREE` or `CTL_CLEAR` goes to `CTL_CLEAR` if bit 0 = 1, otherwise to `CTL_FREE`.

Without a write, `CTL_CLEAR` falls to `CTL_FREE` and every other state stays where it is.

Software uses `CTL_HOLD` to park every timer that runs from the divider. It configures them and then writes bit 7 to 0. All those timers then restart from the same divider phase on one common cycle.

Top module: `tps_hub`

## Requirements
- R1: After reset the control register reads 0x00 and every timer whose selector is 000 receives no enable.
- R2: Bits 6:1 of the control register ignore writes and read 0; bit 7 (group-halt) and bit 0 (divider restart) read back as written, subject to R3 and R5.
- R3: With bit 7 at 0, writing bit 0 = 1 makes it read 1 for exactly one cycle, with no divider enables in that cycle, after which hardware clears it and the divider restarts from zero: the first 1/8 enable comes 7 cycles after the first cycle in which bit 0 reads 0 again.
- R4: With bit 7 at 1, a 1 written to bit 0 is kept, and no divider-derived enable (selectors 001 to 101) is produced while it is held.
- R5: Writing bit 7 = 0 while bit 7 is 1 clears bit 0 in the same write, and all timers resume from divider phase zero on one common cycle: with k = 0 the first cycle after the write, a 1/N source first fires at cycle k = N-1.
- R6: Selector encoding: 001 enables every cycle, and 010, 011, 100 and 101 enable once per 8, 64, 256 and 1024 cycles respectively, at cycles N-1, 2N-1, and so on after a divider restart.
- R7: Selector 111 gives one enable per rising pin edge and 110 gives one per falling pin edge. The enable is high in the second cycle after the clock edge that first samples the new pin level and lasts one cycle. Every edge is counted when each pin level is held for at least two cycles.
- R8: External edge enables bypass the divider and keep working while the divider is held in `CTL_HOLD`.
- R9: Selector 000 stops the timer: its enable stays low whatever the divider or pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit 7 group-halt, bit 0 divider restart) |
| ctl_rdata | output | 8 | Control register read value |
| src_sel | input | 3*N_TMR | Per-timer source selector, timer i in bits 3i+2:3i |
| ext_pin | input | N_TMR | Per-timer external clock pin, asynchronous |
| tick_en | output | N_TMR | Per-timer single-cycle count enable |

## Verification
The bench counts, to the cycle, where the first and later enables of every divider tap fall after a restart. A tap decoded from the wrong counter bits, or a restart that leaves a stale count, moves those cycles and changes the number of enables in a 2048-cycle window. It checks that bit 0 lasts exactly one cycle outside group-halt mode, is held inside it, and is cleared when group-halt mode is left. A state machine that forgot the hardware clear would keep the divider frozen, and one that dropped the held bit would let timers advance during configuration. On the pin path it measures the two-cycle latency, the edge polarity, a 20-edge toggle train and pulses taken during a hold. A missing synchronizer stage, swapped polarities or gating by the divider each show up as a shifted, missing or duplicated enable.

// File: rtl/tps_pkg.sv
package tps_pkg;

    typedef enum logic [2:0] {
        SRC_STOP     = 3'd0,
        SRC_DIV1     = 3'd1,
        SRC_DIV8     = 3'd2,
        SRC_DIV64    = 3'd3,
        SRC_DIV256   = 3'd4,
        SRC_DIV1024  = 3'd5,
        SRC_EXT_FALL = 3'd6,
        SRC_EXT_RISE = 3'd7
    } src_sel_e;

    // state bit 1 mirrors the group-halt bit, state bit 0 the restart bit
    typedef enum logic [1:0] {
        CTL_FREE  = 2'b00,
        CTL_CLEAR = 2'b01,
        CTL_ARMED = 2'b10,
        CTL_HOLD  = 2'b11
    } ctl_state_e;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned HALT_BIT = 7;
    localparam int unsigned RST_BIT  = 0;
    localparam int unsigned SEL_W    = 3;
    localparam int unsigned NUM_TAPS = 5;

    // log2 of the division ratio of each divider tap
    function automatic int unsigned tap_log2(input int unsigned idx);
        case (idx)
            0:       return 0;
            1:       return 3;
            2:       return 6;
            3:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tps_ctl_fsm.sv
module tps_ctl_fsm
    import tps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             div_hold
);

    ctl_state_e state_q, state_d;
    logic       w_halt, w_rst;
    logic       wdata_unused;

    assign w_halt       = wdata[HALT_BIT];
    assign w_rst        = wdata[RST_BIT];
    assign wdata_unused = ^wdata;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (we) begin
            if (w_halt) begin
                state_d = w_rst ? CTL_HOLD : CTL_ARMED;
            end else begin
                unique case (state_q)
                    CTL_ARMED, CTL_HOLD: state_d = CTL_FREE;
                    CTL_FREE, CTL_CLEAR: state_d = w_rst ? CTL_CLEAR : CTL_FREE;
                endcase
            end
        end else begin
            unique case (state_q)
                CTL_CLEAR: state_d = CTL_FREE;
                CTL_FREE:  state_d = CTL_FREE;
                CTL_ARMED: state_d = CTL_ARMED;
                CTL_HOLD:  state_d = CTL_HOLD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_FREE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        rdata    = '0;
        div_hold = 1'b0;
        unique case (state_q)
            CTL_FREE:  ;
            CTL_CLEAR: begin rdata[RST_BIT] = 1'b1; div_hold = 1'b1; end
            CTL_ARMED: rdata[HALT_BIT] = 1'b1;
            CTL_HOLD:  begin
                rdata[HALT_BIT] = 1'b1;
                rdata[RST_BIT]  = 1'b1;
                div_hold        = 1'b1;
            end
        endcase
    end

    assert_clear_self_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[RST_BIT] && !rdata[HALT_BIT] && !we) |=> !rdata[RST_BIT]);

    assert_hold_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[RST_BIT] && rdata[HALT_BIT] && !we) |=> (rdata[RST_BIT] && rdata[HALT_BIT]));

    assert_leave_halt_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wdata[HALT_BIT] && rdata[HALT_BIT]) |=> !rdata[RST_BIT]);

endmodule

// File: rtl/tps_divider.sv
module tps_divider
    import tps_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    output logic [NUM_TAPS-1:0] taps
);

    logic [CNT_W-1:0] cnt_q;
    logic             run;

    assign run = !hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (hold) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        localparam int unsigned L = tap_log2(i);
        if (L == 0) begin : g_full
            assign taps[i] = run;
        end else begin : g_div
            assign taps[i] = run && (&cnt_q[L-1:0]);
        end
    end

    assert_restart_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt_q == '0));

    assert_div8_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        taps[1] |=> !taps[1]);

    assert_hold_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> (taps == '0));

endmodule

// File: rtl/tps_pin_edge.sv
module tps_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);

    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q && !s3_q;
    assign fall = !s2_q && s3_q;

    assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    assert_fall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/tps_src_mux.sv
module tps_src_mux
    import tps_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic                rise,
    input  logic                fall,
    output logic                en
);

    src_sel_e src;
    assign src = src_sel_e'(sel);

    always_comb begin
        unique case (src)
            SRC_STOP:     en = 1'b0;
            SRC_DIV1:     en = taps[0];
            SRC_DIV8:     en = taps[1];
            SRC_DIV64:    en = taps[2];
            SRC_DIV256:   en = taps[3];
            SRC_DIV1024:  en = taps[4];
            SRC_EXT_FALL: en = fall;
            SRC_EXT_RISE: en = rise;
        endcase
    end

    assert_stop_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_STOP) |-> !en);

    assert_ext_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_EXT_RISE && rise) |-> en);

endmodule

// File: rtl/tps_hub.sv
module tps_hub
    import tps_pkg::*;
#(
    parameter int unsigned N_TMR = 2,
    parameter int unsigned CNT_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_we,
    input  logic [7:0]             ctl_wdata,
    output logic [7:0]             ctl_rdata,
    input  logic [N_TMR*SEL_W-1:0] src_sel,
    input  logic [N_TMR-1:0]       ext_pin,
    output logic [N_TMR-1:0]       tick_en
);

    logic                div_hold;
    logic [NUM_TAPS-1:0] taps;

    tps_ctl_fsm u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .rdata    (ctl_rdata),
        .div_hold (div_hold)
    );

    tps_divider #(.CNT_W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (div_hold),
        .taps  (taps)
    );

    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
        logic rise, fall;

        tps_pin_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (ext_pin[t]),
            .rise  (rise),
            .fall  (fall)
        );

        tps_src_mux u_mux (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (src_sel[t*SEL_W +: SEL_W]),
            .taps  (taps),
            .rise  (rise),
            .fall  (fall),
            .en    (tick_en[t])
        );
    end

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (ctl_rdata[6:1] == 6'd0));

endmodule

// File: tb/test_tps_hub.sv
module test_tps_hub;

    localparam int N_TMR = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ctl_we = 1'b0;
    logic [7:0]         ctl_wdata = 8'h00;
    logic [7:0]         ctl_rdata;
    logic [N_TMR*3-1:0] src_sel = '0;
    logic [N_TMR-1:0]   ext_pin = '0;
    logic [N_TMR-1:0]   tick_en;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tps_hub #(.N_TMR(N_TMR), .CNT_W(10)) i_tps_hub (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .src_sel   (src_sel),
        .ext_pin   (ext_pin),
        .tick_en   (tick_en)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // write the register; returns at the negedge of the first cycle after the write edge
    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
        ctl_wdata = 8'h00;
    endtask

    task automatic set_sel(input logic [2:0] s0, input logic [2:0] s1);
        src_sel = {s1, s0};
    endtask

    task automatic t_reset();
        int seen = 0;
        check("R1", "rdata after reset", int'(ctl_rdata), 0);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            seen += int'(tick_en != 0);
        end
        check("R1", "enables with selector 000", seen, 0);
        set_sel(3'b001, 3'b000);
        seen = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            seen += int'(tick_en[0]);
        end
        check("R6", "div1 enables in 6 cycles", seen, 6);
        check("R9", "stopped timer stays low", int'(tick_en[1]), 0);
    endtask

    task automatic t_reserved();
        wr(8'hFE);
        check("R2", "read after 0xFE", int'(ctl_rdata), 8'h80);
        wr(8'h7E);
        check("R2", "read after 0x7E", int'(ctl_rdata), 8'h00);
    endtask

    // restart via group halt, then measure two divider taps over 2048 cycles
    task automatic t_div_pair(input logic [2:0] sa, input int na, input logic [2:0] sb, input int nb);
        int first_a = -1, first_b = -1, cnt_a = 0, cnt_b = 0;
        wr(8'h81);
        set_sel(sa, sb);
        wr(8'h00);
        for (int c = 0; c < 2048; c++) begin
            if (tick_en[0]) begin cnt_a++; if (first_a < 0) first_a = c; end
            if (tick_en[1]) begin cnt_b++; if (first_b < 0) first_b = c; end
            @(negedge clk);
        end
        check("R6", $sformatf("first /%0d enable", na), first_a, na - 1);
        check("R6", $sformatf("count /%0d enables", na), cnt_a, 2048 / na);
        check("R6", $sformatf("first /%0d enable", nb), first_b, nb - 1);
        check("R6", $sformatf("count /%0d enables", nb), cnt_b, 2048 / nb);
    endtask

    task automatic t_hold_release();
        int seen = 0, first0 = -1, first1 = -1;
        set_sel(3'b001, 3'b010);
        wr(8'h81);
        for (int c = 0; c < 40; c++) begin
            seen += int'(tick_en != 0);
            if (ctl_rdata != 8'h81) seen += 100;
            @(negedge clk);
        end
        check("R4", "enables or register change during hold", seen, 0);
        set_sel(3'b010, 3'b010);
        wr(8'h01);
        check("R5", "leaving halt clears restart bit", int'(ctl_rdata), 0);
        for (int c = 0; c < 16; c++) begin
            if (tick_en[0] && first0 < 0) first0 = c;
            if (tick_en[1] && first1 < 0) first1 = c;
            @(negedge clk);
        end
        check("R5", "timer0 first /8 after release", first0, 7);
        check("R5", "timer1 same cycle as timer0", first1, first0);
    endtask

    task automatic t_restart_pulse();
        int first = -1;
        set_sel(3'b010, 3'b000);
        repeat (3) @(negedge clk);
        wr(8'h01);
        check("R3", "restart bit reads 1", int'(ctl_rdata), 1);
        check("R3", "no enable in restart cycle", int'(tick_en[0]), 0);
        @(negedge clk);
        check("R3", "restart bit self-cleared", int'(ctl_rdata), 0);
        for (int c = 0; c < 16; c++) begin
            if (tick_en[0] && first < 0) first = c;
            @(negedge clk);
        end
        check("R3", "first /8 after restart", first, 7);
    endtask

    task automatic t_ext_edges();
        int seen = 0;
        set_sel(3'b111, 3'b110);
        ext_pin = 2'b00;
        repeat (4) @(negedge clk);
        ext_pin = 2'b11;
        @(negedge clk);
        check("R7", "rise not yet after one edge", int'(tick_en[0]), 0);
        @(negedge clk);
        check("R7", "rise enable after two edges", int'(tick_en[0]), 1);
        check("R7", "fall selector ignores rising", int'(tick_en[1]), 0);
        @(negedge clk);
        check("R7", "rise enable lasts one cycle", int'(tick_en[0]), 0);
        repeat (2) @(negedge clk);
        ext_pin = 2'b00;
        @(negedge clk);
        seen += int'(tick_en[0]);
        @(negedge clk);
        check("R7", "fall enable after two edges", int'(tick_en[1]), 1);
        seen += int'(tick_en[0]);
        @(negedge clk);
        check("R7", "fall enable lasts one cycle", int'(tick_en[1]), 0);
        check("R7", "rise selector ignores falling", seen, 0);
        seen = 0;
        for (int k = 0; k < 48; k++) begin
            seen += int'(tick_en[0]);
            if (k < 40 && (k % 2) == 0) ext_pin[0] = ~ext_pin[0];
            @(negedge clk);
        end
        check("R7", "rising enables in 20-edge train", seen, 10);
    endtask

    task automatic t_ext_in_hold();
        set_sel(3'b111, 3'b001);
        ext_pin = 2'b00;
        wr(8'h81);
        repeat (3) @(negedge clk);
        ext_pin[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8", "pin enable during hold", int'(tick_en[0]), 1);
        check("R8", "div1 still halted", int'(tick_en[1]), 0);
        wr(8'h00);
        ext_pin = 2'b00;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reserved();
        t_div_pair(3'b010, 8, 3'b011, 64);
        t_div_pair(3'b100, 256, 3'b101, 1024);
        t_hold_release();
        t_restart_pulse();
        t_ext_edges();
        t_ext_in_hold();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule